// File: doc/BRIEF.md
# Host UART Link with Start-up Greeting

This block is the serial port that faces the host in a host-to-peripheral bridge. It moves bytes in both directions at once over a pair of lines. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit, with no parity. A command engine inside the bridge exchanges bytes with the block through a valid/ready stream in each direction. It can also load a new 16-bit baud divisor through a simple write port.

As soon as reset is released, the block sends the two ASCII bytes "O" (0x4F) and "K" (0x4B) to the host on its own, with no idle bit time between them. Until the second of those bytes has left the line, the transmit stream refuses data. The block divides its clock to a tick at sixteen times the baud rate. The receiver uses that tick to check that a start bit is still low half a bit later, and to sample every later bit at its centre. The divisor resets to the value that gives 9600 bit/s for the configured clock. A new value waits until both directions are idle before it is used.

Top module: `host_uart_link`

## Requirements
- R1: Each transmitted frame is one start bit at 0, eight data bits with bit 0 first, and one stop bit at 1. The line rests at 1 whenever no frame is being sent, including during reset.
- R2: After reset the divisor equals CLK_HZ / (16 × 9600), so one bit lasts 16 × divisor clock cycles.
- R3: With no request from the command engine, the first two frames after reset carry 0x4F and then 0x4B. The second start bit begins as soon as the first stop bit ends, with no idle bit time in between.
- R4: `tx_ready` stays 0 from reset until the second greeting frame has ended. After that, a byte is taken in the cycle where `tx_valid` and `tx_ready` are both 1, and it is sent as one frame.
- R5: A divisor written through `div_we`/`div_wdata` is used only once neither direction has a frame in progress. A frame already under way keeps the old bit time, and later frames use 16 × the new divisor.
- R6: A low pulse on `rxd` that is back to 1 at the middle of the start bit is ignored. It produces no byte and no framing-error pulse, and the receiver then accepts the next genuine frame.
- R7: A received frame whose stop bit samples 0 is thrown away. `rx_valid` does not rise and `rx_data` keeps its value, while `rx_ferr` is 1 for exactly one cycle.
- R8: A good received byte is shown on `rx_data` with `rx_valid` at 1. Both are held until a cycle where `rx_ready` is 1, and `rx_valid` is 0 in the cycle after that.
- R9: Receiving and transmitting run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data from the host |
| txd | output | 1 | Serial data to the host |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| rx_data | output | 8 | Last good received byte |
| rx_valid | output | 1 | `rx_data` holds an unread byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_ferr | output | 1 | One-cycle pulse when a frame is dropped for a bad stop bit |
| div_we | input | 1 | Load a new baud divisor |
| div_wdata | input | 16 | New baud divisor value |

## Verification
Two events can meet in the same cycle. One is a divisor write, which can arrive while a frame is still being shifted. The other is a divisor change that must wait for both the transmitter and the receiver to go idle. The bench writes a slower divisor part-way through a transmitted frame. It then decodes that frame at the old bit time and the next frame at the new bit time. It also starts a received frame and a transmitted frame together at the new rate, and compares both bytes with their expected values.

// File: rtl/host_uart_link.sv
module host_uart_link #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             txd,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_ferr,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata
);
  localparam int              DEF_DIV = CLK_HZ / (16 * BAUD);
  localparam logic [DIV_W-1:0] DIV_RST = DEF_DIV[DIV_W-1:0];
  localparam logic [7:0]      GREET0  = 8'h4F;
  localparam logic [7:0]      GREET1  = 8'h4B;

  logic [DIV_W-1:0] div_new, div_act, bcnt;
  logic [DIV_W:0]   bnext;
  logic             tick;

  logic       tx_on;
  logic [9:0] tx_sh;
  logic [3:0] tx_ph, tx_bit;
  logic [1:0] ban_idx;
  logic       ban_done;

  logic [1:0] rx_s;
  logic       rxs, rx_on;
  logic [3:0] rx_ph, rx_bit;
  logic [7:0] rx_sh;

  assign bnext    = {1'b0, bcnt} + 1'b1;
  assign tick     = bnext >= {1'b0, div_act};
  assign ban_done = ban_idx[1];
  assign tx_ready = ban_done & ~tx_on;
  assign txd      = ~tx_on | tx_sh[0];
  assign rxs      = rx_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt    <= '0;
      div_new <= DIV_RST;
      div_act <= DIV_RST;
    end else begin
      bcnt <= tick ? '0 : bnext[DIV_W-1:0];
      if (div_we) div_new <= div_wdata;
      if (tick && !tx_on && !rx_on) div_act <= div_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on   <= 1'b0;
      tx_sh   <= '1;
      tx_ph   <= '0;
      tx_bit  <= '0;
      ban_idx <= '0;
    end else if (!tx_on) begin
      if (!ban_done) begin
        tx_sh   <= {1'b1, ban_idx[0] ? GREET1 : GREET0, 1'b0};
        tx_on   <= 1'b1;
        tx_ph   <= '0;
        tx_bit  <= '0;
        ban_idx <= ban_idx + 2'd1;
      end else if (tx_valid) begin
        tx_sh  <= {1'b1, tx_data, 1'b0};
        tx_on  <= 1'b1;
        tx_ph  <= '0;
        tx_bit <= '0;
      end
    end else if (tick) begin
      tx_ph <= tx_ph + 4'd1;
      if (tx_ph == 4'hF) begin
        tx_sh  <= {1'b1, tx_sh[9:1]};
        tx_bit <= tx_bit + 4'd1;
        if (tx_bit == 4'd9) tx_on <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s     <= 2'b11;
      rx_on    <= 1'b0;
      rx_ph    <= '0;
      rx_bit   <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_s    <= {rx_s[0], rxd};
      rx_ferr <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!rx_on) begin
        if (!rxs) begin
          rx_on  <= 1'b1;
          rx_ph  <= '0;
          rx_bit <= '0;
        end
      end else if (tick) begin
        rx_ph <= rx_ph + 4'd1;
        if (rx_ph == 4'd7) begin
          rx_bit <= rx_bit + 4'd1;
          if (rx_bit == 4'd0) begin
            if (rxs) rx_on <= 1'b0;
          end else if (rx_bit == 4'd9) begin
            rx_on <= 1'b0;
            if (rxs) begin
              rx_data  <= rx_sh;
              rx_valid <= 1'b1;
            end else begin
              rx_ferr <= 1'b1;
            end
          end else begin
            rx_sh <= {rxs, rx_sh[7:1]};
          end
        end
      end
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> !txd);
  // R4
  ready_after_greet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ban_idx == 2'd2);
  // R5
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> $past(!tx_on && !rx_on));
  // R7
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> !rx_ferr);
  // R7
  ferr_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |-> $stable(rx_data) && !$rose(rx_valid));
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !rx_on |=> rx_valid && $stable(rx_data));
endmodule

// File: tb/host_uart_link_tb.sv
module host_uart_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 16 * 9600 * 2;
  localparam int BIT0       = 32;
  localparam int BIT1       = 64;

  logic        clk = 0, rst_n = 0, rxd = 1;
  logic [7:0]  tx_data = 0;
  logic        tx_valid = 0, rx_ready = 0, div_we = 0;
  logic [15:0] div_wdata = 0;
  logic        txd, tx_ready, rx_valid, rx_ferr;
  logic [7:0]  rx_data;

  int checks = 0, fails = 0, ferr_cnt = 0;

  host_uart_link #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ferr(rx_ferr), .div_we(div_we), .div_wdata(div_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rx_ferr) ferr_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic capture(input int bt, output logic [7:0] b, output bit ok);
    int n = 0;
    ok = 1;
    b = '0;
    @(negedge clk);
    while (txd && n < 4000) begin @(negedge clk); n++; end
    if (txd) begin ok = 0; return; end
    repeat (bt/2) @(negedge clk);
    if (txd) ok = 0;
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      b[i] = txd;
    end
    repeat (bt) @(negedge clk);
    if (!txd) ok = 0;
  endtask

  task automatic send_tx(input logic [7:0] v);
    @(negedge clk);
    tx_data = v;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic send_rx(input logic [7:0] v, input int bt, input logic stopb);
    @(negedge clk);
    rxd = 0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = v[i];
      repeat (bt) @(negedge clk);
    end
    rxd = stopb;
    repeat (bt) @(negedge clk);
    rxd = 1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(txd == 1, "R1 line idle in reset", txd, 1);
    chk(tx_ready == 0, "R4 ready low in reset", tx_ready, 0);
    chk(rx_valid == 0 && rx_ferr == 0, "R8 rx quiet in reset", rx_valid, 0);
  endtask

  task automatic t_greeting();
    logic [7:0] b;
    bit ok;
    int gap = 0;
    rst_n = 1;
    capture(BIT0, b, ok);
    chk(ok, "R1 greeting frame 0 framing", ok, 1);
    chk(b == 8'h4F, "R3 first greeting byte", b, 8'h4F);
    chk(tx_ready == 0, "R4 ready low between greeting bytes", tx_ready, 0);
    while (txd && gap < 200) begin @(negedge clk); gap++; end
    chk(gap <= BIT0/2 + 4, "R3 greeting bytes back to back", gap, BIT0/2);
    capture(BIT0 - 0, b, ok);
    chk(ok, "R1 greeting frame 1 framing", ok, 1);
    chk(b == 8'h4B, "R3 second greeting byte", b, 8'h4B);
    repeat (BIT0) @(negedge clk);
    chk(tx_ready == 1, "R4 ready after greeting", tx_ready, 1);
  endtask

  task automatic t_tx(input logic [7:0] v, input int bt, input string req);
    logic [7:0] b;
    bit ok;
    fork
      send_tx(v);
      capture(bt, b, ok);
    join
    chk(ok, req, ok, 1);
    chk(b == v, req, b, v);
    repeat (bt) @(negedge clk);
  endtask

  task automatic t_rx_hold();
    send_rx(8'h3C, BIT0, 1);
    chk(rx_valid == 1 && rx_data == 8'h3C, "R2 R8 byte received at reset rate", rx_data, 8'h3C);
    repeat (100) @(negedge clk);
    chk(rx_valid == 1 && rx_data == 8'h3C, "R8 byte held until taken", rx_valid, 1);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
    chk(rx_valid == 0, "R8 valid clears after take", rx_valid, 0);
  endtask

  task automatic t_glitch();
    int f0 = ferr_cnt;
    @(negedge clk);
    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (400) @(negedge clk);
    chk(rx_valid == 0, "R6 glitch makes no byte", rx_valid, 0);
    chk(ferr_cnt == f0, "R6 glitch makes no error", ferr_cnt - f0, 0);
    send_rx(8'hC3, BIT0, 1);
    chk(rx_valid == 1 && rx_data == 8'hC3, "R6 recovers after glitch", rx_data, 8'hC3);
    rx_ready = 1;
    @(negedge clk);
    rx_ready = 0;
  endtask

  task automatic t_ferr();
    int f0 = ferr_cnt;
    send_rx(8'h55, BIT0, 0);
    repeat (200) @(negedge clk);
    chk(ferr_cnt - f0 == 1, "R7 one-cycle error pulse", ferr_cnt - f0, 1);
    chk(rx_valid == 0, "R7 bad frame dropped", rx_valid, 0);
    chk(rx_data == 8'hC3, "R7 data unchanged", rx_data, 8'hC3);
  endtask

  task automatic t_div_change();
    logic [7:0] b;
    bit ok;
    fork
      send_tx(8'h81);
      capture(BIT0, b, ok);
      begin
        repeat (100) @(negedge clk);
        div_wdata = 16'd4;
        div_we = 1;
        @(negedge clk);
        div_we = 0;
      end
    join
    chk(ok && b == 8'h81, "R5 frame in flight keeps old rate", b, 8'h81);
    repeat (BIT0) @(negedge clk);
    t_tx(8'h6E, BIT1, "R5 new rate on next frame");
  endtask

  task automatic t_duplex();
    logic [7:0] b;
    bit ok;
    fork
      send_tx(8'hB7);
      capture(BIT1, b, ok);
      send_rx(8'h9A, BIT1, 1);
    join
    chk(ok && b == 8'hB7, "R9 tx byte during rx", b, 8'hB7);
    chk(rx_valid == 1 && rx_data == 8'h9A, "R9 rx byte during tx", rx_data, 8'h9A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_greeting();
    t_tx(8'hA5, BIT0, "R1 R4 tx A5");
    t_tx(8'h00, BIT0, "R1 tx 00");
    t_tx(8'hFF, BIT0, "R1 tx FF");
    t_rx_hold();
    t_glitch();
    t_ferr();
    t_div_change();
    t_duplex();
    finish_run();
  end
endmodule